// File: doc/BRIEF.md
# Host Command Submission Queue

This block sits behind a host-visible submission window. Each store the host makes into that window is treated as one command: the address picks a channel, a subchannel and a method slot. The store data travels with that decoded tag into a small on-chip queue. The queue's write and read positions are kept as Gray-coded indices. Software can read them directly: the write index is shown as is, and the read index is shown as a byte offset.

On the drain side, the entry at the head of the queue is matched against a context word held for its own subchannel. If one flag bit in that word is set, the entry is a software method. It is then not offered to the graphics engine. Instead it is captured into a trap register set and raises a level interrupt to the host. Other entries are handed to the engine through a valid/ready handshake. A queue overrun also raises the interrupt. Both interrupt causes are cleared by writing ones to a status clear port.

Top module: `cmd_submit_fifo`

## Requirements
- R1: Address decoding uses the offset from the window base (default 0x0080_0000). Bits [22:16] of the offset give the channel, and bits [15:13] give the subchannel. The method offset is the address ANDed with 0x1FFC and is output as a 13-bit byte offset. Queued entries reach `eng_*` in arrival order and carry that tag and the data word.
- R2: A store is ignored when its address lies below the window base or at or above base + 0x80_0000.
- R3: A store is ignored while `push_en` is low.
- R4: The queue has 32 slots, of which 31 can be used. It is full when the advanced write index equals the read index. A store that arrives while the queue is full is dropped and sets the overrun flag.
- R5: `put_gray` equals the Gray code n ^ (n >> 1) of the accepted store count modulo 32, and exactly one bit changes on each accepted store.
- R6: `get_byte` equals the Gray code of the drained entry count modulo 32, shifted left by 2.
- R7: The head entry's own subchannel selects its context word. If bit 23 of that word is set, the entry is removed without appearing on `eng_valid`. Its channel, subchannel, method and data are latched on `trap_*`, and the software-method flag is set. No other context bit has any effect.
- R8: While the software-method flag is set, a software-method entry at the head waits in the queue and `eng_valid` stays low. The trapped values do not change.
- R9: `irq` is high exactly while the software-method flag (status bit 0) or the overrun flag (status bit 1) is set. A `stat_clr_wr` pulse clears each flag whose data bit is 1. A flag being set in the same cycle takes priority over its clear.
- R10: While `eng_valid` is high and `eng_ready` is low, the offered entry stays unchanged.
- R11: After reset the queue is empty, both indices are 0, `irq` is low and all context words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Enables queue pushes |
| host_wr | input | 1 | Host store strobe |
| host_addr | input | 32 | Host store address |
| host_wdata | input | 32 | Host store data |
| ctx_wr | input | 1 | Context word write strobe |
| ctx_sel | input | 3 | Subchannel whose context is written |
| ctx_wdata | input | 32 | Context word value |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_data | input | 2 | Ones clear flags: bit 0 software method, bit 1 overrun |
| eng_valid | output | 1 | Head entry offered to the engine |
| eng_ready | input | 1 | Engine accepts the offered entry |
| eng_chan | output | 7 | Channel of offered entry |
| eng_subch | output | 3 | Subchannel of offered entry |
| eng_method | output | 13 | Method byte offset of offered entry |
| eng_data | output | 32 | Data of offered entry |
| trap_chan | output | 7 | Channel of trapped software method |
| trap_subch | output | 3 | Subchannel of trapped software method |
| trap_method | output | 13 | Method byte offset of trapped software method |
| trap_data | output | 32 | Data of trapped software method |
| irq | output | 1 | Level interrupt |
| put_gray | output | 5 | Gray-coded write index |
| get_byte | output | 7 | Gray-coded read index shifted left by 2 |

## Verification
A corrupted write or read index becomes visible at once. In the cycle after the offending store or drain, `put_gray` or `get_byte` stops matching the Gray code of the running count. A wrong full or empty decision shows up no later than the 32nd store, as a missing or spurious overrun interrupt or as an entry offered twice or lost. Routing against the wrong context word is seen on the first store to the subchannel concerned. Its entry appears on `eng_*` when it should have been trapped on `trap_*`, or the reverse.

// File: rtl/cmd_submit_pkg.sv
package cmd_submit_pkg;

   typedef enum int {
      ST_SWM = 0,
      ST_OVF = 1
   } stat_bit_e;

   function automatic logic [15:0] to_gray(input logic [15:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [15:0] from_gray(input logic [15:0] g);
      logic [15:0] r;
      r = g;
      for (int i = 1; i < 16; i++) r = r ^ (g >> i);
      return r;
   endfunction

endpackage

// File: rtl/cmd_addr_decode.sv
module cmd_addr_decode #(
   parameter int ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0080_0000,
   parameter int CHAN_W   = 7,
   parameter int SUBCH_W  = 3,
   parameter int SUB_LOG2 = 13
) (
   input  logic [ADDR_W-1:0]     addr,
   output logic                  hit,
   output logic [CHAN_W-1:0]     chan,
   output logic [SUBCH_W-1:0]    subch,
   output logic [SUB_LOG2-3:0]   mword
);
   localparam int SLICE_LOG2 = SUB_LOG2 + SUBCH_W;
   localparam int SPAN_LOG2  = SLICE_LOG2 + CHAN_W;

   logic [ADDR_W-1:0] offs;

   always_comb begin
      offs  = addr - WIN_BASE;
      hit   = (addr >= WIN_BASE) && ((offs >> SPAN_LOG2) == '0);
      chan  = offs[SLICE_LOG2 +: CHAN_W];
      subch = offs[SUB_LOG2 +: SUBCH_W];
      mword = offs[2 +: SUB_LOG2-2];
   end
endmodule

// File: rtl/cmd_gray_ptr.sv
module cmd_gray_ptr #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] gray,
   output logic [W-1:0] nxt_gray
);
   logic [W-1:0] g_q;
   logic [W-1:0] bin;
   logic [W-1:0] bin_inc;

   assign bin[W-1] = g_q[W-1];
   generate
      for (genvar i = W - 2; i >= 0; i--) begin : g_unfold
         assign bin[i] = bin[i+1] ^ g_q[i];
      end
   endgenerate

   assign bin_inc  = bin + 1'b1;
   assign nxt_gray = bin_inc ^ (bin_inc >> 1);
   assign gray     = g_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   g_q <= '0;
      else if (adv) g_q <= nxt_gray;
   end
endmodule

// File: rtl/cmd_queue_mem.sv
module cmd_queue_mem #(
   parameter int IDX_W   = 5,
   parameter int ENTRY_W = 53
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_data
);
   localparam int SLOTS = 1 << IDX_W;

   logic [ENTRY_W-1:0] slot_q [SLOTS];

   always_ff @(posedge clk) begin
      if (wr_en) slot_q[wr_idx] <= wr_data;
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/cmd_ctx_regs.sv
module cmd_ctx_regs #(
   parameter int SEL_W  = 3,
   parameter int CTX_W  = 32,
   parameter int SW_BIT = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CTX_W-1:0] wr_data,
   input  logic [SEL_W-1:0] look_sel,
   output logic             look_sw
);
   localparam int NREG = 1 << SEL_W;

   logic [NREG-1:0] sw_flag;

   generate
      for (genvar k = 0; k < NREG; k++) begin : g_ctx
         logic [CTX_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                         word_q <= '0;
            else if (wr && wr_sel == SEL_W'(k)) word_q <= wr_data;
         end
         assign sw_flag[k] = word_q[SW_BIT];
      end
   endgenerate

   assign look_sw = sw_flag[look_sel];
endmodule

// File: rtl/cmd_submit_fifo.sv
module cmd_submit_fifo
   import cmd_submit_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0080_0000,
   parameter int CHAN_W     = 7,
   parameter int SUBCH_W    = 3,
   parameter int SUB_LOG2   = 13,
   parameter int DEPTH_LOG2 = 5,
   parameter int CTX_W      = 32,
   parameter int SW_BIT     = 23,
   parameter int STAT_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_en,
   input  logic                 host_wr,
   input  logic [ADDR_W-1:0]    host_addr,
   input  logic [DATA_W-1:0]    host_wdata,
   input  logic                 ctx_wr,
   input  logic [SUBCH_W-1:0]   ctx_sel,
   input  logic [CTX_W-1:0]     ctx_wdata,
   input  logic                 stat_clr_wr,
   input  logic [STAT_W-1:0]    stat_clr_data,
   output logic                 eng_valid,
   input  logic                 eng_ready,
   output logic [CHAN_W-1:0]    eng_chan,
   output logic [SUBCH_W-1:0]   eng_subch,
   output logic [SUB_LOG2-1:0]  eng_method,
   output logic [DATA_W-1:0]    eng_data,
   output logic [CHAN_W-1:0]    trap_chan,
   output logic [SUBCH_W-1:0]   trap_subch,
   output logic [SUB_LOG2-1:0]  trap_method,
   output logic [DATA_W-1:0]    trap_data,
   output logic                 irq,
   output logic [DEPTH_LOG2-1:0] put_gray,
   output logic [DEPTH_LOG2+1:0] get_byte
);
   localparam int MWORD_W = SUB_LOG2 - 2;
   localparam int ENTRY_W = CHAN_W + SUBCH_W + MWORD_W + DATA_W;
   localparam int PTR_W   = DEPTH_LOG2;

   generate
      if (SUB_LOG2 < 3)
         $error("subchannel slice must hold at least two words");
      if (SUB_LOG2 + SUBCH_W + CHAN_W > ADDR_W)
         $error("submission window wider than the address");
      if (SW_BIT >= CTX_W)
         $error("software flag outside the context word");
      if (DEPTH_LOG2 < 2 || DEPTH_LOG2 > 10)
         $error("queue depth out of range");
      if (STAT_W != 2)
         $error("status carries exactly two flags");
   endgenerate

   // address decode
   logic                win_hit;
   logic [CHAN_W-1:0]   d_chan;
   logic [SUBCH_W-1:0]  d_subch;
   logic [MWORD_W-1:0]  d_mword;

   cmd_addr_decode #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .CHAN_W(CHAN_W),
      .SUBCH_W(SUBCH_W), .SUB_LOG2(SUB_LOG2)
   ) u_dec (
      .addr(host_addr), .hit(win_hit), .chan(d_chan),
      .subch(d_subch), .mword(d_mword)
   );

   // pointers
   logic [PTR_W-1:0] put_g, put_nxt, get_g, get_nxt;
   logic             empty, full;
   logic             push_try, push_ok, push_drop;
   logic             pop, eng_pop, sw_take;

   assign empty     = (put_g == get_g);
   assign full      = (put_nxt == get_g);
   assign push_try  = host_wr && win_hit && push_en;
   assign push_ok   = push_try && !full;
   assign push_drop = push_try && full;

   cmd_gray_ptr #(.W(PTR_W)) u_put (
      .clk(clk), .rst_n(rst_n), .adv(push_ok),
      .gray(put_g), .nxt_gray(put_nxt)
   );

   cmd_gray_ptr #(.W(PTR_W)) u_get (
      .clk(clk), .rst_n(rst_n), .adv(pop),
      .gray(get_g), .nxt_gray(get_nxt)
   );

   // storage, indexed by the Gray value itself
   logic [ENTRY_W-1:0] wr_entry, head;
   logic [CHAN_W-1:0]  h_chan;
   logic [SUBCH_W-1:0] h_subch;
   logic [MWORD_W-1:0] h_mword;
   logic [DATA_W-1:0]  h_data;

   assign wr_entry = {d_chan, d_subch, d_mword, host_wdata};

   cmd_queue_mem #(.IDX_W(PTR_W), .ENTRY_W(ENTRY_W)) u_mem (
      .clk(clk), .wr_en(push_ok), .wr_idx(put_g), .wr_data(wr_entry),
      .rd_idx(get_g), .rd_data(head)
   );

   assign {h_chan, h_subch, h_mword, h_data} = head;

   // context lookup by the head entry's subchannel
   logic head_sw;

   cmd_ctx_regs #(.SEL_W(SUBCH_W), .CTX_W(CTX_W), .SW_BIT(SW_BIT)) u_ctx (
      .clk(clk), .rst_n(rst_n), .wr(ctx_wr), .wr_sel(ctx_sel),
      .wr_data(ctx_wdata), .look_sel(h_subch), .look_sw(head_sw)
   );

   // routing
   logic swm_pend, ovf_pend;

   assign eng_valid = !empty && !head_sw;
   assign eng_pop   = eng_valid && eng_ready;
   assign sw_take   = !empty && head_sw && !swm_pend;
   assign pop       = eng_pop || sw_take;

   assign eng_chan   = h_chan;
   assign eng_subch  = h_subch;
   assign eng_method = {h_mword, 2'b00};
   assign eng_data   = h_data;

   // status flags
   logic clr_swm, clr_ovf;
   assign clr_swm = stat_clr_wr && stat_clr_data[ST_SWM];
   assign clr_ovf = stat_clr_wr && stat_clr_data[ST_OVF];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         swm_pend <= 1'b0;
         ovf_pend <= 1'b0;
      end else begin
         swm_pend <= sw_take   || (swm_pend && !clr_swm);
         ovf_pend <= push_drop || (ovf_pend && !clr_ovf);
      end
   end

   // trap capture
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_chan   <= '0;
         trap_subch  <= '0;
         trap_method <= '0;
         trap_data   <= '0;
      end else if (sw_take) begin
         trap_chan   <= h_chan;
         trap_subch  <= h_subch;
         trap_method <= {h_mword, 2'b00};
         trap_data   <= h_data;
      end
   end

   assign irq      = swm_pend || ovf_pend;
   assign put_gray = put_g;
   assign get_byte = {get_g, 2'b00};
endmodule

// File: rtl/cmd_submit_fifo_chk.sv
module cmd_submit_fifo_chk #(
   parameter int PTR_W  = 5,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              push_en,
   input logic              win_hit,
   input logic              full,
   input logic [PTR_W-1:0]  put_g,
   input logic              ctx_wr,
   input logic              eng_valid,
   input logic              eng_ready,
   input logic [DATA_W-1:0] eng_data,
   input logic              swm_pend,
   input logic              ovf_pend,
   input logic [DATA_W-1:0] trap_data
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && push_en && win_hit && full |=> (put_g == $past(put_g)) && ovf_pend); // R4

   AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !push_en |=> put_g == $past(put_g)); // R3

   AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      put_g != $past(put_g) |-> $countones(put_g ^ $past(put_g)) == 1); // R5

   AST_ENG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      eng_valid && !eng_ready && !ctx_wr |=> eng_valid && $stable(eng_data)); // R10

   AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      swm_pend |=> $stable(trap_data)); // R8
endmodule

bind cmd_submit_fifo cmd_submit_fifo_chk #(.PTR_W(DEPTH_LOG2), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .push_en(push_en),
   .win_hit(win_hit), .full(full), .put_g(put_g), .ctx_wr(ctx_wr),
   .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_data(eng_data),
   .swm_pend(swm_pend), .ovf_pend(ovf_pend), .trap_data(trap_data)
);

// File: tb/cmd_submit_fifo_test.sv
`timescale 1ns/1ps
module cmd_submit_fifo_test;
   localparam logic [31:0] BASE = 32'h0080_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_en = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        ctx_wr = 1'b0;
   logic [2:0]  ctx_sel = '0;
   logic [31:0] ctx_wdata = '0;
   logic        stat_clr_wr = 1'b0;
   logic [1:0]  stat_clr_data = '0;
   logic        eng_valid;
   logic        eng_ready = 1'b0;
   logic [6:0]  eng_chan;
   logic [2:0]  eng_subch;
   logic [12:0] eng_method;
   logic [31:0] eng_data;
   logic [6:0]  trap_chan;
   logic [2:0]  trap_subch;
   logic [12:0] trap_method;
   logic [31:0] trap_data;
   logic        irq;
   logic [4:0]  put_gray;
   logic [6:0]  get_byte;

   int n_chk = 0;
   int n_bad = 0;
   int n_push = 0;
   int n_pop = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cmd_submit_fifo uut (
      .clk(clk), .rst_n(rst_n), .push_en(push_en), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .ctx_wr(ctx_wr),
      .ctx_sel(ctx_sel), .ctx_wdata(ctx_wdata), .stat_clr_wr(stat_clr_wr),
      .stat_clr_data(stat_clr_data), .eng_valid(eng_valid), .eng_ready(eng_ready),
      .eng_chan(eng_chan), .eng_subch(eng_subch), .eng_method(eng_method),
      .eng_data(eng_data), .trap_chan(trap_chan), .trap_subch(trap_subch),
      .trap_method(trap_method), .trap_data(trap_data), .irq(irq),
      .put_gray(put_gray), .get_byte(get_byte)
   );

   function automatic logic [4:0] gray5(input int n);
      logic [4:0] b;
      b = 5'(n % 32);
      return b ^ (b >> 1);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_store(input logic [31:0] a, input logic [31:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic drain_one();
      eng_ready = 1'b1;
      @(negedge clk);
      eng_ready = 1'b0;
   endtask

   task automatic ctx_write(input logic [2:0] s, input logic [31:0] v);
      ctx_wr = 1'b1; ctx_sel = s; ctx_wdata = v;
      @(negedge clk);
      ctx_wr = 1'b0;
   endtask

   task automatic stat_clear(input logic [1:0] m);
      stat_clr_wr = 1'b1; stat_clr_data = m;
      @(negedge clk);
      stat_clr_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, d;
      int chs[4];
      int ms[3];
      chs = '{0, 1, 42, 127};
      ms  = '{0, 'h1FFC, 'h0A5F};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check("R11 eng_valid", 32'(eng_valid), 0);
      check("R11 irq", 32'(irq), 0);
      check("R11 put_gray", 32'(put_gray), 0);
      check("R11 get_byte", 32'(get_byte), 0);

      push_en = 1'b1;

      // R1 R5 R6 sweep over channels, all subchannels, methods
      foreach (chs[ci]) begin
         for (int sc = 0; sc < 8; sc++) begin
            foreach (ms[mi]) begin
               a = BASE + (32'(chs[ci]) << 16) + (32'(sc) << 13) + 32'(ms[mi]);
               d = 32'hC0DE_0000 ^ (32'(chs[ci]) << 20) ^ (32'(sc) << 16) ^ 32'(ms[mi]);
               host_store(a, d);
               n_push++;
               check("R1 valid", 32'(eng_valid), 1);
               check("R1 chan", 32'(eng_chan), 32'(chs[ci]));
               check("R1 subch", 32'(eng_subch), 32'(sc));
               check("R1 method", 32'(eng_method), 32'(ms[mi]) & 32'h1FFC);
               check("R1 data", eng_data, d);
               check("R5 put_gray", 32'(put_gray), 32'(gray5(n_push)));
               drain_one();
               n_pop++;
               check("R6 get_byte", 32'(get_byte), 32'(gray5(n_pop)) << 2);
               check("R1 empty after drain", 32'(eng_valid), 0);
            end
         end
      end

      // R3 gate closed
      push_en = 1'b0;
      host_store(BASE + 32'h40, 32'h1111_1111);
      check("R3 no entry", 32'(eng_valid), 0);
      check("R3 put unchanged", 32'(put_gray), 32'(gray5(n_push)));
      push_en = 1'b1;

      // R2 outside window
      host_store(BASE - 32'd4, 32'h2222_2222);
      check("R2 below base", 32'(eng_valid), 0);
      host_store(BASE + 32'h0080_0000, 32'h3333_3333);
      check("R2 above top", 32'(eng_valid), 0);
      check("R2 put unchanged", 32'(put_gray), 32'(gray5(n_push)));
      host_store(BASE + 32'h007F_FFFC, 32'h4444_4444);
      n_push++;
      check("R2 last word accepted", 32'(eng_valid), 1);
      check("R2 last word chan", 32'(eng_chan), 127);
      drain_one();
      n_pop++;

      // R4 fill to 31, then overrun
      for (int i = 0; i < 31; i++) begin
         host_store(BASE + (32'(i) << 2), 32'hF000_0000 + 32'(i));
         n_push++;
      end
      check("R4 no overrun at 31", 32'(irq), 0);
      check("R5 put after fill", 32'(put_gray), 32'(gray5(n_push)));
      host_store(BASE + 32'h100, 32'hDEAD_BEEF);
      check("R4 overrun irq", 32'(irq), 1);
      check("R4 dropped put", 32'(put_gray), 32'(gray5(n_push)));
      for (int i = 0; i < 31; i++) begin
         check("R4 drain order", eng_data, 32'hF000_0000 + 32'(i));
         drain_one();
         n_pop++;
      end
      check("R4 empty after drain", 32'(eng_valid), 0);
      stat_clear(2'b10);
      check("R9 overrun cleared", 32'(irq), 0);

      // R7 R8 software methods
      ctx_write(3'd3, 32'h0080_0000);
      ctx_write(3'd2, 32'hFF7F_FFFF);
      host_store(BASE + (32'd5 << 16) + (32'd3 << 13) + 32'h0124, 32'hAAAA_0001);
      host_store(BASE + (32'd6 << 16) + (32'd2 << 13) + 32'h0200, 32'hBBBB_0002);
      host_store(BASE + (32'd7 << 16) + (32'd3 << 13) + 32'h0300, 32'hCCCC_0003);
      check("R7 irq", 32'(irq), 1);
      check("R7 trap chan", 32'(trap_chan), 5);
      check("R7 trap subch", 32'(trap_subch), 3);
      check("R7 trap method", 32'(trap_method), 32'h0124);
      check("R7 trap data", trap_data, 32'hAAAA_0001);
      check("R7 other bits forward", 32'(eng_valid), 1);
      check("R7 forwarded data", eng_data, 32'hBBBB_0002);
      drain_one();
      check("R8 held, no eng", 32'(eng_valid), 0);
      check("R8 trap unchanged", trap_data, 32'hAAAA_0001);
      stat_clear(2'b01);
      check("R9 swm cleared", 32'(irq), 0);
      @(negedge clk);
      check("R8 second trap irq", 32'(irq), 1);
      check("R8 second trap data", trap_data, 32'hCCCC_0003);
      check("R8 second trap chan", 32'(trap_chan), 7);
      check("R6 read index after traps", 32'(get_byte), 32'(gray5(n_pop + 3)) << 2);
      stat_clear(2'b01);
      check("R9 final clear", 32'(irq), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule